// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between several processors and one small shared memory. It gives them the primitives needed to build locks and other atomic read-modify-write sequences. Each processor presents one request at a time: a plain load, a plain store, a load-linked or a store-conditional. A round-robin arbiter admits one request per cycle. The memory access takes place on that cycle's clock edge, and the answer returns on the following cycle.

A load-linked returns the word and records a reservation for the issuing processor on that address. A later store-conditional from the same processor commits its data only if that reservation is still held. Any committed write to the address by another processor, whether a plain store or a winning store-conditional, removes the reservation. The response carries a pass/fail bit. A failing store-conditional leaves both memory and all reservations exactly as they were. When two processors race store-conditionals to the same word, the arbiter decides: the first one granted commits and kills the other's reservation.

Top module: `llsc_monitor`

## Requirements
- R1: Each processor drives a 2-bit operation code: 0 = load, 1 = store, 2 = load-linked, 3 = store-conditional. A load returns the current memory word on `rsp_data`, with the requester's bit set in `rsp_valid`, exactly one cycle after its grant.
- R2: A load-linked returns the memory word, like a load, and records a reservation for the issuing processor on that address.
- R3: A store-conditional whose processor holds a reservation on the same address commits its write data and returns `rsp_ok` = 1.
- R4: A failed store-conditional returns `rsp_ok` = 0. It writes nothing to memory and leaves every reservation unchanged, including the issuer's own.
- R5: A plain store clears the reservations that other processors hold on the same address. Reservations on other addresses survive it.
- R6: When two processors issue store-conditionals to one reserved address, the first one granted succeeds and the other fails.
- R7: Each processor holds at most one reservation. A new load-linked replaces the previous one, so a store-conditional to the older address fails.
- R8: A store-conditional fails if its processor holds no reservation, or holds one on a different address.
- R9: A successful store-conditional clears the issuing processor's own reservation, so an immediate second store-conditional fails.
- R10: At most one grant is active per cycle, and only to a requesting processor. Simultaneous requests are served round-robin, each requester once, in cyclically increasing index order.
- R11: After reset no response is valid, no reservation is held and every memory word reads 0. `rsp_ok` is 0 for any non-store-conditional response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request pending, one bit per processor, held until granted |
| req_op | input | 2*NPROC | Operation code per processor |
| req_addr | input | AW*NPROC | Word address per processor |
| req_wdata | input | DW*NPROC | Write data per processor |
| req_grant | output | NPROC | Combinational grant; the request is consumed at the next edge |
| rsp_valid | output | NPROC | One-hot response strobe, one cycle after the grant |
| rsp_data | output | DW | Memory word read by the granted access, before any write |
| rsp_ok | output | 1 | Store-conditional success bit |

## Verification
A grant is combinational and is visible in the same cycle the request is driven. Its response is registered and is due exactly one clock edge later. The bench reads the grant shortly after it drives the request on the falling edge. It pushes the expected response into a queue at that point. The monitor pops one entry on each falling edge that shows a response, which is exactly the next cycle, so a late, early or misrouted answer shows up as a mismatch. Memory effects of a store-conditional, such as a committed or suppressed write, are confirmed by a following load, whose data is due one cycle after its own grant.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } op_e;

  // Round-robin pick: first requester at or after 'start', wrapping; -1 if none.
  function automatic int rr_pick(input int n, input int start, input logic [31:0] req);
    int pick;
    pick = -1;
    for (int k = 31; k >= 0; k--) begin
      if (k < n) begin
        int idx;
        idx = start + k;
        if (idx >= n) idx = idx - n;
        if (req[idx]) pick = idx;
      end
    end
    return pick;
  endfunction

  // A reservation matches when it is live and on the same word.
  function automatic logic resv_match(input logic live, input logic [31:0] held,
                                      input logic [31:0] addr);
    return live && (held == addr);
  endfunction

endpackage

// File: rtl/llsc_rr_arbiter.sv
module llsc_rr_arbiter #(
  parameter int NPROC = 4,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] req,
  output logic [NPROC-1:0] grant,
  output logic [IW-1:0]    win_idx,
  output logic             fire
);
  import llsc_pkg::*;

  logic [IW-1:0] ptr_q;
  int            pick;

  always_comb begin
    logic [31:0] req_ext;
    req_ext = '0;
    req_ext[NPROC-1:0] = req;
    pick    = rr_pick(NPROC, int'(ptr_q), req_ext);
    fire    = rst_n && (pick >= 0);
    win_idx = (pick >= 0) ? IW'(pick) : '0;
    grant   = '0;
    if (fire) grant[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (fire) begin
      ptr_q <= (int'(win_idx) == NPROC - 1) ? '0 : win_idx + 1'b1;
    end
  end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int NPROC = 4,
  parameter int AW    = 4,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  llsc_pkg::op_e    op,
  input  logic [IW-1:0]    who,
  input  logic [AW-1:0]    addr,
  output logic             sc_pass,
  output logic             wr_commit,
  output logic [NPROC-1:0] resv_valid
);
  import llsc_pkg::*;

  logic [AW-1:0] held_q [NPROC];
  logic          own_hit;

  always_comb begin
    own_hit   = resv_match(resv_valid[who], 32'(held_q[who]), 32'(addr));
    sc_pass   = fire && (op == OP_SC) && own_hit;
    wr_commit = (fire && (op == OP_STORE)) || sc_pass;
  end

  for (genvar q = 0; q < NPROC; q++) begin : g_slot
    logic is_me;
    assign is_me = (int'(who) == q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resv_valid[q] <= 1'b0;
        held_q[q]     <= '0;
      end else if (fire && (op == OP_LL) && is_me) begin
        resv_valid[q] <= 1'b1;
        held_q[q]     <= addr;
      end else if (wr_commit && resv_match(resv_valid[q], 32'(held_q[q]), 32'(addr))
                   && (!is_me || op == OP_SC)) begin
        resv_valid[q] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/llsc_shared_mem.sv
module llsc_shared_mem #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else begin
      if (rd_en) rdata <= words[addr];
      if (wr_en) words[addr] <= wdata;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NPROC = 4,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPROC-1:0]   req_valid,
  input  logic [2*NPROC-1:0] req_op,
  input  logic [AW*NPROC-1:0] req_addr,
  input  logic [DW*NPROC-1:0] req_wdata,
  output logic [NPROC-1:0]   req_grant,
  output logic [NPROC-1:0]   rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_ok
);
  import llsc_pkg::*;
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;

  // Named internal events for the checker
  logic [IW-1:0]    win_idx;
  logic             acc_fire;
  logic             acc_we;
  logic             sc_try;
  logic             ll_try;
  logic             sc_pass;
  logic [NPROC-1:0] resv_valid;
  op_e              win_op;
  logic [AW-1:0]    win_addr;
  logic [DW-1:0]    win_wdata;

  llsc_rr_arbiter #(.NPROC(NPROC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .grant(req_grant), .win_idx(win_idx), .fire(acc_fire)
  );

  always_comb begin
    win_op    = op_e'(req_op[win_idx*2 +: 2]);
    win_addr  = req_addr[win_idx*AW +: AW];
    win_wdata = req_wdata[win_idx*DW +: DW];
    sc_try    = acc_fire && (win_op == OP_SC);
    ll_try    = acc_fire && (win_op == OP_LL);
  end

  llsc_resv_table #(.NPROC(NPROC), .AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_n), .fire(acc_fire), .op(win_op), .who(win_idx),
    .addr(win_addr), .sc_pass(sc_pass), .wr_commit(acc_we), .resv_valid(resv_valid)
  );

  llsc_shared_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_fire), .wr_en(acc_we),
    .addr(win_addr), .wdata(win_wdata), .rdata(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= req_grant;
      rsp_ok    <= sc_pass;
    end
  end

endmodule

// File: rtl/llsc_checker.sv
module llsc_checker #(
  parameter int NPROC = 4,
  parameter int IW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] req_valid,
  input logic [NPROC-1:0] req_grant,
  input logic [NPROC-1:0] rsp_valid,
  input logic             acc_we,
  input logic             sc_try,
  input logic             ll_try,
  input logic             sc_pass,
  input logic [IW-1:0]    win_idx,
  input logic [NPROC-1:0] resv_valid
);

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));

  assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);

  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    |req_grant |=> rsp_valid == $past(req_grant));

  assert_sc_fail_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_try && !sc_pass) |-> !acc_we);

  assert_ll_reserves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ll_try |=> resv_valid[$past(win_idx)]);

  assert_sc_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |=> !resv_valid[$past(win_idx)]);

endmodule

bind llsc_monitor llsc_checker #(.NPROC(NPROC), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .rsp_valid(rsp_valid), .acc_we(acc_we), .sc_try(sc_try), .ll_try(ll_try),
  .sc_pass(sc_pass), .win_idx(win_idx), .resv_valid(resv_valid)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [1:0]    op_a    [NP];
  logic [AW-1:0] addr_a  [NP];
  logic [DW-1:0] wdata_a [NP];
  logic [2*NP-1:0]  req_op;
  logic [AW*NP-1:0] req_addr;
  logic [DW*NP-1:0] req_wdata;
  logic [NP-1:0] req_grant, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_ok;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      req_op[i*2 +: 2]     = op_a[i];
      req_addr[i*AW +: AW] = addr_a[i];
      req_wdata[i*DW +: DW] = wdata_a[i];
    end
  end

  llsc_monitor #(.NPROC(NP), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  typedef struct {
    int            p;
    logic [DW-1:0] d;
    bit            cmpd;
    bit            ok;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic void chk(bit cond, string tag, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  // Monitor: pops one expected item per observed response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && |rsp_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected response", int'(rsp_valid), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_valid == NP'(1 << e.p), e.tag, "rsp_valid", int'(rsp_valid), 1 << e.p);
          if (e.cmpd) chk(rsp_data == e.d, e.tag, "rsp_data", int'(rsp_data), int'(e.d));
          chk(rsp_ok == e.ok, e.tag, "rsp_ok", int'(rsp_ok), int'(e.ok));
        end
      end
    end
  end

  task automatic setreq(int p, logic [1:0] op, int a, int wd);
    op_a[p] = op; addr_a[p] = AW'(a); wdata_a[p] = DW'(wd);
    req_valid[p] = 1'b1;
  endtask

  task automatic push(int p, int d, bit cmpd, bit ok, string tag);
    exp_t e;
    e.p = p; e.d = DW'(d); e.cmpd = cmpd; e.ok = ok; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: one request, wait for grant, queue the expectation
  task automatic issue(int p, logic [1:0] op, int a, int wd, int expd, bit cmpd,
                       bit ok, string tag);
    @(negedge clk);
    setreq(p, op, a, wd);
    #1;
    while (!req_grant[p]) begin
      @(negedge clk);
      #1;
    end
    push(p, expd, cmpd, ok, tag);
    @(negedge clk);
    req_valid[p] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      op_a[i] = LD; addr_a[i] = '0; wdata_a[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, "R11", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(rsp_ok == 1'b0, "R11", "rsp_ok after reset", int'(rsp_ok), 0);

    // R11 / R1: memory clear, load timing
    issue(0, LD, 3, 0, 0, 1, 0, "R11");
    issue(1, LD, 15, 0, 0, 1, 0, "R11");
    issue(1, ST, 3, 'h1234, 0, 0, 0, "R1");
    issue(2, LD, 3, 0, 'h1234, 1, 0, "R1");

    // R2 / R3: LL then SC commits
    issue(0, LL, 5, 0, 0, 1, 0, "R2");
    issue(0, SC, 5, 'h00AA, 0, 0, 1, "R3");
    issue(3, LD, 5, 0, 'h00AA, 1, 0, "R3");
    // R9: second SC fails, memory unchanged
    issue(0, SC, 5, 'h0BAD, 0, 0, 0, "R9");
    issue(3, LD, 5, 0, 'h00AA, 1, 0, "R9");

    // R5: other processor's store kills reservation; R4: no write on fail
    issue(1, LL, 6, 0, 0, 1, 0, "R5");
    issue(2, ST, 6, 'h0007, 0, 0, 0, "R5");
    issue(1, SC, 6, 'h0099, 0, 0, 0, "R5");
    issue(3, LD, 6, 0, 'h0007, 1, 0, "R4");
    // R5: store to another address leaves reservation alone
    issue(1, LL, 7, 0, 0, 1, 0, "R5");
    issue(2, ST, 8, 'h0001, 0, 0, 0, "R5");
    issue(1, SC, 7, 'h0055, 0, 0, 1, "R5");

    // R7: new LL replaces old
    issue(3, LL, 9, 0, 0, 1, 0, "R7");
    issue(3, LL, 10, 0, 0, 1, 0, "R7");
    issue(3, SC, 9, 'h0011, 0, 0, 0, "R7");
    issue(3, SC, 10, 'h0022, 0, 0, 1, "R7");
    issue(0, LD, 9, 0, 0, 1, 0, "R7");

    // R8: no reservation / wrong address; R4: failed SC keeps reservation
    issue(2, SC, 11, 'h0033, 0, 0, 0, "R8");
    issue(2, LL, 11, 0, 0, 1, 0, "R8");
    issue(2, SC, 12, 'h0044, 0, 0, 0, "R8");
    issue(0, LD, 12, 0, 0, 1, 0, "R8");
    issue(2, SC, 11, 'h0033, 0, 0, 1, "R4");

    // R6: race of two store-conditionals
    issue(0, LL, 13, 0, 0, 1, 0, "R6");
    issue(1, LL, 13, 0, 0, 1, 0, "R6");
    begin
      int w, l;
      @(negedge clk);
      setreq(0, SC, 13, 'h0100);
      setreq(1, SC, 13, 'h0200);
      #1;
      w = req_grant[0] ? 0 : 1;
      l = 1 - w;
      chk(req_grant[w] && !req_grant[l], "R6", "single grant", int'(req_grant), 1 << w);
      push(w, 0, 0, 1, "R6");
      @(negedge clk);
      req_valid[w] = 1'b0;
      #1;
      chk(req_grant[l] == 1'b1, "R6", "loser granted next", int'(req_grant), 1 << l);
      push(l, 0, 0, 0, "R6");
      @(negedge clk);
      req_valid[l] = 1'b0;
      issue(3, LD, 13, 0, (w == 0) ? 'h0100 : 'h0200, 1, 0, "R6");
    end

    // R10: all request at once, round-robin order
    begin
      int order [NP];
      bit seen [NP];
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        setreq(i, LD, 0, 0);
        seen[i] = 1'b0;
      end
      for (int k = 0; k < NP; k++) begin
        int g;
        #1;
        g = -1;
        for (int i = 0; i < NP; i++) if (req_grant[i]) g = i;
        chk($countones(req_grant) == 1, "R10", "one grant", int'(req_grant), 1);
        if (g < 0) g = 0;
        order[k] = g;
        chk(!seen[g], "R10", "repeat grant", g, -1);
        seen[g] = 1'b1;
        push(g, 0, 1, 0, "R10");
        @(negedge clk);
        req_valid[g] = 1'b0;
      end
      for (int k = 0; k + 1 < NP; k++)
        chk(order[k+1] == (order[k] + 1) % NP, "R10", "cyclic order",
            order[k+1], (order[k] + 1) % NP);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1", "responses outstanding", q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule